// File: doc/BRIEF.md
# Fractional UART baud-rate generator

This block turns a fast reference clock into the timing strobes a UART needs: a one-cycle oversample tick and a one-cycle bit tick. The spacing between oversample ticks comes from a 16-bit integer divisor and a 4-bit fraction. Each oversample period lasts either DIV or DIV+1 reference cycles. Over every run of 16 periods, exactly FRACT of them are the longer kind. The average period is therefore DIV + FRACT/16, exact to 1/16 of a reference cycle. The price is cycle-to-cycle jitter whenever the fraction is non-zero.

Software picks the divisor for a target rate as D = f_ref × M / (16 × baud), where M is 1, 2 or 4 for the 16x, 8x or 4x oversampling modes. The integer part of D is written as two byte registers. The rounded sixteenths of the remainder are written as the fraction. A square-ish divided clock is also produced, and an enable gates it onto a pin-level output. Any number of instances can share one reference clock, each with its own settings.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low, `os_tick`, `bit_tick`, `div_clk` and `pin_clk` are 0. Reset loads divisor 1, fraction 0 and the 16x mode. The first oversample period starts in the cycle after the first clock edge with `rst_n` high.
- R2: The divisor is `{div_hi, div_lo}`, 16 bits wide, written one byte at a time with separate strobes. Registers not written keep their value. A divisor of 0 behaves as 1.
- R3: After a restart, oversample period k (k = 0, 1, ...) lasts DIV+1 cycles when floor((k+1)·F/16) > floor(k·F/16), and DIV cycles otherwise. `os_tick` is high for exactly the last cycle of each period.
- R4: The first 16 oversample periods after a restart together last exactly 16·DIV + F reference cycles.
- R5: The `rate_mode` encoding is 00 for 16x, 01 for 8x, and 10 or 11 for 4x. `bit_tick` is high together with every N-th `os_tick` after a restart, where N is 16, 8 or 4, and at no other time.
- R6: `div_clk` is high for the first floor(L/2) cycles of every oversample period of length L, and low for the rest. With L = 1 it stays low.
- R7: A write strobe on any divisor, fraction or mode input restarts the phase. The period counter, the fraction phase and the oversample count all clear, and period 0 under the new settings begins in the cycle after the write edge. Earlier timing has no effect on what follows.
- R8: `pin_clk` equals `div_clk` while `clk_pin_en` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_div_lo | input | 1 | Write strobe for the divisor low byte |
| div_lo | input | 8 | Divisor low byte |
| wr_div_hi | input | 1 | Write strobe for the divisor high byte |
| div_hi | input | 8 | Divisor high byte |
| wr_frac | input | 1 | Write strobe for the fraction |
| frac_in | input | 4 | Fraction in sixteenths |
| wr_mode | input | 1 | Write strobe for the rate mode |
| rate_mode | input | 2 | Oversampling mode select |
| clk_pin_en | input | 1 | Routes the divided clock to `pin_clk` |
| os_tick | output | 1 | One-cycle strobe at the end of each oversample period |
| bit_tick | output | 1 | One-cycle strobe once per bit time |
| div_clk | output | 1 | Divided clock level |
| pin_clk | output | 1 | Gated divided clock for a pin |

## Verification
The outputs are decoded directly from registers, so after a write edge the first sample of the new timing falls in the very next cycle. That cycle is position 0 of period 0. `os_tick` is due at position L−1 of each period, and `bit_tick` on the N-th such tick. Every bench task starts on the falling edge that follows its last write strobe and compares all four outputs on every falling edge against positions computed from the floor formula in R3. It does not track tick counts relative to the design. The 16-period total is taken from the cycle index of the 16th observed tick.

// File: rtl/baud_pkg.sv
// Package: shared types and helpers for the fractional baud-rate generator.
// Assumes: rate mode is a 2-bit code; the two upper codes both mean 4x.
package baud_pkg;

    typedef enum logic [1:0] {
        RATE_X16  = 2'b00,
        RATE_X8   = 2'b01,
        RATE_X4   = 2'b10,
        RATE_X4_B = 2'b11
    } rate_e;

    // Number of oversample ticks that make up one bit time.
    function automatic logic [4:0] os_per_bit(rate_e m);
        case (m)
            RATE_X16: return 5'd16;
            RATE_X8:  return 5'd8;
            default:  return 5'd4;
        endcase
    endfunction

endpackage

// File: rtl/baud_regs.sv
// Module: setting registers for the generator.
// Holds divisor bytes, fraction and rate mode; flags a restart on any write.
// Assumes: write strobes are single-cycle or level, sampled on clk.
module baud_regs
    import baud_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 4,
    localparam int DIV_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] lo_d,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] hi_d,
    input  logic              wr_frac,
    input  logic [FRAC_W-1:0] frac_d,
    input  logic              wr_mode,
    input  logic [1:0]        mode_d,
    output logic [DIV_W-1:0]  eff_div,
    output logic [FRAC_W-1:0] frac_q,
    output rate_e             mode_q,
    output logic              restart
);

    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;

    // Capture each setting on its own strobe; reset to divisor 1, fraction 0, 16x.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= BYTE_W'(1);
            hi_q   <= '0;
            frac_q <= '0;
            mode_q <= RATE_X16;
        end else begin
            if (wr_lo)   lo_q   <= lo_d;
            if (wr_hi)   hi_q   <= hi_d;
            if (wr_frac) frac_q <= frac_d;
            if (wr_mode) mode_q <= rate_e'(mode_d);
        end
    end

    // Any write restarts the timing chain at the same edge.
    assign restart = wr_lo | wr_hi | wr_frac | wr_mode;

    // A zero divisor is clamped to one reference cycle.
    always_comb begin
        eff_div = {hi_q, lo_q};
        if (eff_div == '0) eff_div = DIV_W'(1);
    end

endmodule

// File: rtl/baud_period.sv
// Module: oversample period counter with fractional dithering.
// Each period is DIV cycles, stretched by one when the fraction phase
// accumulator carries. Also forms the divided clock level.
// Assumes: eff_div >= 1 and settings change only together with restart.
module baud_period #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [DIV_W-1:0]  eff_div,
    input  logic [FRAC_W-1:0] frac,
    output logic              run,
    output logic              os_tick,
    output logic              div_clk
);

    localparam logic [DIV_W:0] ONE = (DIV_W+1)'(1);

    logic [DIV_W-1:0]  cnt;
    logic [FRAC_W-1:0] phase;
    logic [FRAC_W:0]   sum;
    logic              stretch;
    logic [DIV_W:0]    len;
    logic [DIV_W:0]    half;
    logic              last;

    // Length of the current period from the phase carry.
    always_comb begin
        sum     = {1'b0, phase} + {1'b0, frac};
        stretch = sum[FRAC_W];
        len     = {1'b0, eff_div} + {{DIV_W{1'b0}}, stretch};
        half    = len >> 1;
        last    = ({1'b0, cnt} == len - ONE);
    end

    // Advance the period counter and the fraction phase; clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt   <= '0;
            phase <= '0;
            run   <= rst_n;
        end else begin
            run <= 1'b1;
            if (run) begin
                if (last) begin
                    cnt   <= '0;
                    phase <= sum[FRAC_W-1:0];
                end else begin
                    cnt <= cnt + DIV_W'(1);
                end
            end
        end
    end

    assign os_tick = run && last;
    assign div_clk = run && ({1'b0, cnt} < half);

endmodule

// File: rtl/baud_bitcnt.sv
// Module: counts oversample ticks and strobes once per bit time.
// Assumes: mode is stable between restarts.
module baud_bitcnt
    import baud_pkg::*;
#(
    parameter int OSC_W = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart,
    input  logic  os_tick,
    input  rate_e mode,
    output logic  bit_tick
);

    logic [OSC_W-1:0] oscnt;
    logic [4:0]       nticks;
    logic             wrap;

    // Wrap point from the selected oversampling factor.
    always_comb begin
        nticks = os_per_bit(mode);
        wrap   = (5'(oscnt) == nticks - 5'd1);
    end

    // Count oversample ticks modulo the factor; clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            oscnt <= '0;
        end else if (os_tick) begin
            oscnt <= wrap ? '0 : oscnt + OSC_W'(1);
        end
    end

    assign bit_tick = os_tick && wrap;

endmodule

// File: rtl/frac_baud_gen.sv
// Module: fractional UART baud-rate generator, top level.
// Produces oversample and bit strobes plus a divided clock from clk.
// Assumes: one clock domain; register writes arrive as strobes on clk.
module frac_baud_gen
    import baud_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 4,
    parameter int OSC_W  = 4,
    localparam int DIV_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_div_lo,
    input  logic [BYTE_W-1:0] div_lo,
    input  logic              wr_div_hi,
    input  logic [BYTE_W-1:0] div_hi,
    input  logic              wr_frac,
    input  logic [FRAC_W-1:0] frac_in,
    input  logic              wr_mode,
    input  logic [1:0]        rate_mode,
    input  logic              clk_pin_en,
    output logic              os_tick,
    output logic              bit_tick,
    output logic              div_clk,
    output logic              pin_clk
);

    logic [DIV_W-1:0]  eff_div;
    logic [FRAC_W-1:0] frac_q;
    rate_e             mode_q;
    logic              restart;
    logic              run;

    baud_regs #(.BYTE_W(BYTE_W), .FRAC_W(FRAC_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (wr_div_lo),
        .lo_d    (div_lo),
        .wr_hi   (wr_div_hi),
        .hi_d    (div_hi),
        .wr_frac (wr_frac),
        .frac_d  (frac_in),
        .wr_mode (wr_mode),
        .mode_d  (rate_mode),
        .eff_div (eff_div),
        .frac_q  (frac_q),
        .mode_q  (mode_q),
        .restart (restart)
    );

    baud_period #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) i_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .eff_div (eff_div),
        .frac    (frac_q),
        .run     (run),
        .os_tick (os_tick),
        .div_clk (div_clk)
    );

    baud_bitcnt #(.OSC_W(OSC_W)) i_bitcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .os_tick  (os_tick),
        .mode     (mode_q),
        .bit_tick (bit_tick)
    );

    // Pin-level copy of the divided clock, gated by its enable.
    assign pin_clk = clk_pin_en && div_clk;

endmodule

// File: rtl/baud_chk.sv
// Checker: timing properties of the baud generator, bound to the top.
// Tracks the elapsed length of each period with its own counter.
module baud_chk #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restart,
    input logic              run,
    input logic [DIV_W-1:0]  eff_div,
    input logic [FRAC_W-1:0] frac,
    input logic              os_tick,
    input logic              bit_tick,
    input logic              div_clk
);

    logic [DIV_W:0] gap;
    logic [DIV_W:0] seen_len;

    // Cycles elapsed in the current period, counted independently.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) gap <= '0;
        else if (os_tick)              gap <= '0;
        else                           gap <= gap + (DIV_W+1)'(1);
    end

    assign seen_len = gap + (DIV_W+1)'(1);

    AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |-> (seen_len == {1'b0, eff_div}) ||
                    ((frac != '0) && (seen_len == {1'b0, eff_div} + (DIV_W+1)'(1)))); // R3

    AST_BIT_ON_OS: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick); // R5

    AST_RESTART_NO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !bit_tick); // R7

    AST_DIVCLK_LOW_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        os_tick |-> !div_clk); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!os_tick && !div_clk)); // R1

endmodule

bind frac_baud_gen baud_chk #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .run      (run),
    .eff_div  (eff_div),
    .frac     (frac_q),
    .os_tick  (os_tick),
    .bit_tick (bit_tick),
    .div_clk  (div_clk)
);

// File: tb/test_frac_baud_gen.sv
`timescale 1ns/1ps
module test_frac_baud_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_div_lo = 1'b0, wr_div_hi = 1'b0, wr_frac = 1'b0, wr_mode = 1'b0;
    logic [7:0] div_lo = '0, div_hi = '0;
    logic [3:0] frac_in = '0;
    logic [1:0] rate_mode = '0;
    logic       clk_pin_en = 1'b0;
    logic       os_tick, bit_tick, div_clk, pin_clk;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    frac_baud_gen i_frac_baud_gen (
        .clk(clk), .rst_n(rst_n),
        .wr_div_lo(wr_div_lo), .div_lo(div_lo),
        .wr_div_hi(wr_div_hi), .div_hi(div_hi),
        .wr_frac(wr_frac), .frac_in(frac_in),
        .wr_mode(wr_mode), .rate_mode(rate_mode),
        .clk_pin_en(clk_pin_en),
        .os_tick(os_tick), .bit_tick(bit_tick),
        .div_clk(div_clk), .pin_clk(pin_clk)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Length of period k after a restart (from R3).
    function automatic int plen(int d, int f, int k);
        return d + ((k + 1) * f) / 16 - (k * f) / 16;
    endfunction

    // One-cycle write of a single setting; starts and ends on a falling edge.
    task automatic write_one(int sel, int val);
        case (sel)
            0: begin wr_div_lo = 1'b1; div_lo = 8'(val); end
            1: begin wr_div_hi = 1'b1; div_hi = 8'(val); end
            2: begin wr_frac = 1'b1; frac_in = 4'(val); end
            default: begin wr_mode = 1'b1; rate_mode = 2'(val); end
        endcase
        @(negedge clk);
        wr_div_lo = 1'b0; wr_div_hi = 1'b0; wr_frac = 1'b0; wr_mode = 1'b0;
    endtask

    // Compare every output each cycle over nper periods from a restart.
    task automatic run_check(string name, int d, int f, int md, int nper);
        int eff = (d == 0) ? 1 : d;
        int nb  = (md == 0) ? 16 : (md == 1) ? 8 : 4;
        int k = 0, pos = 0, cyc = 0, ticks = 0, t16 = -1;
        int len = plen(eff, f, 0);
        int os_err = 0, bit_err = 0, hi_err = 0, pin_err = 0;
        int fa = -1, fe = -1, ba = -1, be = -1;
        while (k < nper) begin
            bit e_os  = (pos == len - 1);
            bit e_hi  = (pos < len / 2);
            bit e_bit = e_os && (((k + 1) % nb) == 0);
            if (os_tick !== e_os) begin
                if (os_err == 0) begin fa = cyc; fe = int'(e_os); end
                os_err++;
            end
            if (bit_tick !== e_bit) begin
                if (bit_err == 0) begin ba = cyc; be = int'(e_bit); end
                bit_err++;
            end
            if (div_clk !== e_hi) hi_err++;
            if (pin_clk !== (clk_pin_en && e_hi)) pin_err++;
            if (os_tick === 1'b1) begin
                ticks++;
                if (ticks == 16) t16 = cyc + 1;
            end
            if (e_os) begin
                k++;
                pos = 0;
                len = plen(eff, f, k);
            end else begin
                pos++;
            end
            cyc++;
            @(negedge clk);
        end
        check(os_err == 0, "R3", {name, " os_tick mismatches (first at cycle)"}, fa, fe);
        check(bit_err == 0, "R5", {name, " bit_tick mismatches (first at cycle)"}, ba, be);
        check(hi_err == 0, "R6", {name, " div_clk mismatched cycles"}, hi_err, 0);
        check(pin_err == 0, "R8", {name, " pin_clk mismatched cycles"}, pin_err, 0);
        if (nper >= 16)
            check(t16 == 16 * eff + f, "R4", {name, " cycles for 16 periods"}, t16, 16 * eff + f);
    endtask

    // R1: outputs quiet in reset, defaults after release.
    task automatic test_reset();
        int bad = 0;
        clk_pin_en = 1'b1;
        repeat (5) begin
            @(negedge clk);
            if (os_tick || bit_tick || div_clk || pin_clk) bad++;
        end
        check(bad == 0, "R1", "outputs active during reset", bad, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_check("R1 defaults", 1, 0, 0, 32);
    endtask

    // R2, R3, R5: full programming with each setting written separately.
    task automatic test_program(string name, int d, int f, int md, bit en, int nper);
        clk_pin_en = en;
        write_one(1, d >> 8);
        write_one(0, d & 255);
        write_one(2, f);
        write_one(3, md);
        run_check(name, d, f, md, nper);
    endtask

    // R7: rewrite one field mid-period; timing restarts from a clean boundary.
    task automatic test_restart();
        clk_pin_en = 1'b1;
        write_one(1, 0);
        write_one(0, 9);
        write_one(2, 7);
        write_one(3, 1);
        repeat (13) @(negedge clk);
        write_one(2, 7);
        run_check("R7 restart same frac", 9, 7, 1, 16);
        repeat (4) @(negedge clk);
        write_one(0, 6);
        run_check("R7 R2 low byte only", 6, 7, 1, 16);
    endtask

    initial begin
        test_reset();
        test_program("R3 d5 f0 x16", 5, 0, 0, 1'b1, 32);
        test_program("R3 d5 f3 x16", 5, 3, 0, 1'b0, 32);
        test_program("R5 d6 f15 x8", 6, 15, 1, 1'b1, 32);
        test_program("R5 d4 f8 x4", 4, 8, 2, 1'b1, 16);
        test_program("R5 d3 f1 mode3", 3, 1, 3, 1'b1, 16);
        test_program("R2 d258 f9", 258, 9, 2, 1'b1, 16);
        test_program("R2 zero div f0", 0, 0, 1, 1'b1, 24);
        test_program("R2 zero div f5", 0, 5, 2, 1'b1, 32);
        test_restart();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual 1 expected 0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule